// File: doc/BRIEF.md
# Multi-Hart Machine Timer

A shared machine-level timer for a small multi-core system. The block keeps one 64-bit time counter, which advances by one on every cycle where the timebase tick input is high, and one 64-bit compare register per hart. Each hart has a timer interrupt line. The line is high while that hart's compare value is at or below the counter. Software can rewrite the counter, and every hart's interrupt then follows the new counter value.

The register port is a simple synchronous request/response bus. A request is presented for one cycle. The response (valid, read data, error) arrives on the next cycle. A size flag selects between a 32-bit and a 64-bit access, so software with either word size can reach both halves of every register. The counter window and the compare window sit at parameter offsets. The compare register of hart n lives 8*n bytes above the compare base.

Top module: `mtmr_top`

## Requirements
- R1: After reset the counter reads 0, every compare register reads all ones, and every interrupt output is low.
- R2: The counter increases by exactly one on each cycle with the tick input high and holds its value otherwise.
- R3: Reads of the counter work as follows. A 64-bit read at the time base returns the full value. A 32-bit read at the time base returns the low half in bits 31:0. A 32-bit read at time base +4 returns the high half in bits 31:0. Upper data bits of a 32-bit read are zero, and writes return zero data.
- R4: Writes to the counter work as follows. A 32-bit write at the time base replaces bits 31:0 and keeps bits 63:32. A 32-bit write at time base +4 replaces bits 63:32 and keeps bits 31:0. A 64-bit write at the time base replaces all 64 bits. A counter write in the same cycle as a tick takes the written value with no increment.
- R5: A 64-bit access at time base +4 sets the error flag, returns zero data, and leaves the counter unchanged.
- R6: The compare register of hart n sits at compare base + 8*n. A 32-bit write at offset 0 replaces bits 31:0 and keeps bits 63:32. A 32-bit write at offset 4 replaces bits 63:32 and keeps bits 31:0. A 64-bit write at offset 0 replaces all 64 bits. Reads follow the same size rules as R3.
- R7: A 64-bit access at compare offset 4 sets the error flag, returns zero data, and leaves the compare register unchanged.
- R8: Interrupt n is a registered output. It equals the unsigned comparison compare[n] <= counter, taken one cycle earlier. A compare write already at or below the counter raises the line one cycle after the write takes effect.
- R9: A counter write re-evaluates every hart at once, so lines may set or clear together one cycle after the write.
- R10: Some accesses are unmapped: an address outside both windows, a compare slot at or beyond the hart count, or an offset within a register other than 0 or 4. These accesses set the error flag, read as zero, and change no register.
- R11: Every request receives exactly one response, with the valid flag high on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick, advances the counter |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 64 | Write data, bits 31:0 used by 32-bit writes |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Access was rejected |
| irq_o | output | NUM_HARTS | Timer interrupt per hart |

## Verification
A corrupted compare half shows up at the ports in two ways. The next 64-bit read-back mismatches, and the interrupt line settles on the wrong side of a boundary. The bench puts compare values one below, equal to and one above the counter in each half, for every hart, and checks the line two cycles after the write. A counter that slips or fails to merge halves shows up in the first read after the write. A decode fault shows up in the response to the access itself, one cycle later, either as a wrong error flag or as nonzero data on a rejected access. The sweep covers every byte offset of the compare window and of the counter window in both sizes.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int unsigned MAX_HARTS = 8;
    localparam int unsigned SLOT_W    = $clog2(MAX_HARTS);
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned HALF_W    = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TIME = 2'd1,
        TGT_CMP  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic              hi;
        logic [SLOT_W-1:0] slot;
        logic              err;
    } dec_t;

    // New register value after a write of the given size and half.
    function automatic word_t merge_wr(input word_t cur, input word_t wd,
                                       input logic wide, input logic hi);
        if (wide)
            return wd;
        else if (hi)
            return {wd[HALF_W-1:0], cur[HALF_W-1:0]};
        else
            return {cur[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
    endfunction

    // Read data for the given size and half.
    function automatic word_t pick_rd(input word_t cur, input logic wide,
                                      input logic hi);
        if (wide)
            return cur;
        else if (hi)
            return {{HALF_W{1'b0}}, cur[WORD_W-1:HALF_W]};
        else
            return {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/mtmr_decode.sv
module mtmr_decode
    import mtmr_pkg::*;
#(
    parameter int unsigned           NUM_HARTS = 2,
    parameter int unsigned           ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]     CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0]     TIME_BASE = 16'h7FF8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NUM_HARTS);

    logic [ADDR_W-1:0] rel;
    logic              off_ok;
    logic              in_time;
    logic              in_cmp;

    always_comb begin
        rel     = addr - CMP_BASE;
        in_time = (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
        in_cmp  = (rel < CMP_SPAN);
        off_ok  = (addr[2:0] == 3'd0) || (addr[2:0] == 3'd4 && !wide);

        dec      = '0;
        dec.hi   = addr[2];
        dec.slot = rel[SLOT_W+2:3];
        if (in_time && off_ok)
            dec.tgt = TGT_TIME;
        else if (in_cmp && off_ok)
            dec.tgt = TGT_CMP;
        else
            dec.tgt = TGT_NONE;
        dec.err = (dec.tgt == TGT_NONE);
    end

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
    import mtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  wr_en,
    input  logic  wr_wide,
    input  logic  wr_hi,
    input  word_t wr_data,
    output word_t time_q
);
    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (wr_en)
            time_q <= merge_wr(time_q, wr_data, wr_wide, wr_hi);
        else if (tick)
            time_q <= time_q + word_t'(1);
    end

endmodule

// File: rtl/mtmr_cmp_slot.sv
module mtmr_cmp_slot
    import mtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_wide,
    input  logic  wr_hi,
    input  word_t wr_data,
    input  word_t time_q,
    output word_t cmp_q,
    output logic  irq_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '1;
        else if (wr_en)
            cmp_q <= merge_wr(cmp_q, wr_data, wr_wide, wr_hi);
    end

    // Registered compare: follows every change of either operand one cycle later.
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= (cmp_q <= time_q);
    end

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int unsigned       NUM_HARTS = 2,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 req_valid_i,
    input  logic                 req_we_i,
    input  logic                 req_wide_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [63:0]          req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [63:0]          rsp_rdata_o,
    output logic                 rsp_err_o,
    output logic [NUM_HARTS-1:0] irq_o
);
    dec_t  dec;
    logic  wr_ok;
    word_t time_q;
    word_t cmp_q [NUM_HARTS];
    word_t rd_val;

    mtmr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .CMP_BASE  (CMP_BASE),
        .TIME_BASE (TIME_BASE)
    ) u_dec (
        .addr (req_addr_i),
        .wide (req_wide_i),
        .dec  (dec)
    );

    assign wr_ok = req_valid_i && req_we_i && !dec.err;

    mtmr_counter u_ctr (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .wr_en   (wr_ok && dec.tgt == TGT_TIME),
        .wr_wide (req_wide_i),
        .wr_hi   (dec.hi),
        .wr_data (req_wdata_i),
        .time_q  (time_q)
    );

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
        mtmr_cmp_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_ok && dec.tgt == TGT_CMP && dec.slot == SLOT_W'(g)),
            .wr_wide (req_wide_i),
            .wr_hi   (dec.hi),
            .wr_data (req_wdata_i),
            .time_q  (time_q),
            .cmp_q   (cmp_q[g]),
            .irq_q   (irq_o[g])
        );
    end

    always_comb begin
        rd_val = '0;
        if (dec.tgt == TGT_TIME)
            rd_val = pick_rd(time_q, req_wide_i, dec.hi);
        else if (dec.tgt == TGT_CMP) begin
            for (int i = 0; i < NUM_HARTS; i++)
                if (dec.slot == SLOT_W'(i))
                    rd_val = pick_rd(cmp_q[i], req_wide_i, dec.hi);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= req_valid_i && dec.err;
            rsp_rdata_o <= (req_valid_i && !req_we_i) ? rd_val : '0;
        end
    end

endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
    parameter int unsigned       NUM_HARTS = 2,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_i,
    input logic                 req_valid_i,
    input logic                 req_we_i,
    input logic                 req_wide_i,
    input logic [ADDR_W-1:0]    req_addr_i,
    input logic                 rsp_valid_o,
    input logic [63:0]          rsp_rdata_o,
    input logic                 rsp_err_o,
    input logic [NUM_HARTS-1:0] irq_o,
    input logic [63:0]          time_q
);
    logic any_wr;
    assign any_wr = req_valid_i && req_we_i;

    // R2: one tick, no write, counter moves by one
    p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !any_wr) |=> (time_q == $past(time_q) + 64'd1));

    // R2: no tick, no write, counter holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !any_wr) |=> $stable(time_q));

    // R5: 64-bit write at the high-half offset leaves the counter alone
    p_wide_hi_time_r5: assert property (@(posedge clk) disable iff (rst)
        (any_wr && req_wide_i && !tick_i && req_addr_i == TIME_BASE + ADDR_W'(4))
        |=> $stable(time_q));

    // R10: rejected accesses carry no data
    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_err_o |-> (rsp_rdata_o == 64'd0 && rsp_valid_o));

    // R11: each request answered on the next cycle
    p_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    p_no_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !rsp_valid_o);

    // R8: without writes and without wrap, a raised line stays raised
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        p_irq_keep_r8: assert property (@(posedge clk) disable iff (rst)
            (irq_o[h] && !$past(any_wr) && !any_wr && $past(time_q) != 64'hFFFF_FFFF_FFFF_FFFF)
            |=> irq_o[h]);
    end

endmodule

bind mtmr_top mtmr_chk #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .TIME_BASE (TIME_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_wide_i  (req_wide_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o),
    .irq_o       (irq_o),
    .time_q      (time_q)
);

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;
    localparam int          NH = 3;
    localparam logic [15:0] TB = 16'h7FF8;
    localparam logic [15:0] CB = 16'h0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rv = 1'b0, we = 1'b0, wide = 1'b0;
    logic [15:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        rsp_v, rsp_e;
    logic [63:0] rsp_d;
    logic [NH-1:0] irq;

    int total = 0;
    int bad = 0;

    logic [63:0] t_m;
    logic [63:0] c_m [NH];
    logic [63:0] got_d;
    logic        got_e, got_v;

    always #4 clk = ~clk;

    mtmr_top #(.NUM_HARTS(NH), .ADDR_W(16), .CMP_BASE(CB), .TIME_BASE(TB)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick),
        .req_valid_i(rv), .req_we_i(we), .req_wide_i(wide),
        .req_addr_i(addr), .req_wdata_i(wdata),
        .rsp_valid_o(rsp_v), .rsp_rdata_o(rsp_d), .rsp_err_o(rsp_e),
        .irq_o(irq)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic wd, input logic [15:0] a,
                       input logic [63:0] d, input logic tk);
        @(negedge clk);
        rv = 1'b1; we = w; wide = wd; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        rv = 1'b0; we = 1'b0; tick = 1'b0;
        got_d = rsp_d; got_e = rsp_e; got_v = rsp_v;
    endtask

    function automatic logic [63:0] mrg(input logic [63:0] c, input logic [63:0] d,
                                        input logic wd, input logic hi);
        if (wd) return d;
        if (hi) return {d[31:0], c[31:0]};
        return {c[63:32], d[31:0]};
    endfunction

    // Expected error and data for a read, from the address map rules.
    task automatic expect_rd(input logic [15:0] a, input logic wd,
                             output logic e, output logic [63:0] d);
        logic [63:0] v;
        logic        ok_off;
        int          rel;
        ok_off = (a[2:0] == 3'd0) || (a[2:0] == 3'd4 && !wd);
        rel = int'(a) - int'(CB);
        e = 1'b1; d = '0; v = '0;
        if (ok_off && a[15:3] == TB[15:3]) begin e = 1'b0; v = t_m; end
        else if (ok_off && rel >= 0 && rel < 8*NH) begin e = 1'b0; v = c_m[rel/8]; end
        if (!e) d = wd ? v : (a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic        ee;
        logic [63:0] ed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_m = '0;
        for (int i = 0; i < NH; i++) c_m[i] = '1;

        // R1 reset state
        chk(irq == '0, "R1 irq", 64'(irq), 64'd0);
        bus(0, 1, TB, 0, 0);
        chk(got_d == 64'd0 && !got_e, "R1 time", got_d, 64'd0);
        for (int i = 0; i < NH; i++) begin
            bus(0, 1, CB + 16'(8*i), 0, 0);
            chk(got_d == '1, "R1 cmp", got_d, '1);
        end

        // R11 response timing
        @(negedge clk);
        rv = 1'b1; addr = TB; wide = 1'b1; we = 1'b0;
        chk(rsp_v == 1'b0, "R11 no early rsp", 64'(rsp_v), 0);
        @(negedge clk);
        rv = 1'b0;
        chk(rsp_v == 1'b1, "R11 rsp next cycle", 64'(rsp_v), 1);
        @(negedge clk);
        chk(rsp_v == 1'b0, "R11 single rsp", 64'(rsp_v), 0);

        // R4 counter writes, R3 reads
        bus(1, 1, TB, 64'h1234_5678_9ABC_DEF0, 0); t_m = 64'h1234_5678_9ABC_DEF0;
        chk(got_d == 0, "R3 write returns zero", got_d, 0);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R4 wide write", got_d, t_m);
        bus(1, 0, TB, 64'hFFFF_FFFF_0000_0011, 0); t_m = mrg(t_m, 64'hFFFF_FFFF_0000_0011, 0, 0);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R4 low half keeps high", got_d, t_m);
        bus(1, 0, TB + 16'd4, 64'h0000_0000_0000_0022, 0); t_m = mrg(t_m, 64'h22, 0, 1);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R4 high half keeps low", got_d, t_m);
        bus(0, 0, TB, 0, 0);
        chk(got_d == {32'd0, t_m[31:0]}, "R3 narrow low read", got_d, {32'd0, t_m[31:0]});
        bus(0, 0, TB + 16'd4, 0, 0);
        chk(got_d == {32'd0, t_m[63:32]}, "R3 narrow high read", got_d, {32'd0, t_m[63:32]});

        // R5 wide access at +4 rejected
        bus(1, 1, TB + 16'd4, 64'hDEAD_BEEF_DEAD_BEEF, 0);
        chk(got_e == 1'b1, "R5 err flag", 64'(got_e), 1);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R5 counter kept", got_d, t_m);

        // R2 ticks
        @(negedge clk); tick = 1'b1;
        repeat (37) @(negedge clk);
        tick = 1'b0; t_m = t_m + 64'd37;
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R2 tick count", got_d, t_m);
        repeat (5) @(negedge clk);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R2 hold without tick", got_d, t_m);

        // R4 write beats tick
        bus(1, 0, TB, 64'h0000_0000_0000_0500, 1); t_m = mrg(t_m, 64'h500, 0, 0);
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R4 write wins over tick", got_d, t_m);

        // R6/R7/R8 sweep over every hart around the boundary
        bus(1, 1, TB, 64'h0000_0010_0000_0080, 0); t_m = 64'h0000_0010_0000_0080;
        for (int h = 0; h < NH; h++) begin
            for (int dh = -1; dh <= 1; dh++) begin
                for (int dl = -1; dl <= 1; dl++) begin
                    logic [63:0] cv;
                    cv = {32'(32'h10 + dh), 32'(32'h80 + dl)};
                    bus(1, 0, CB + 16'(8*h) + 16'd4, {32'd0, cv[63:32]}, 0);
                    c_m[h] = mrg(c_m[h], {32'd0, cv[63:32]}, 0, 1);
                    bus(0, 1, CB + 16'(8*h), 0, 0);
                    chk(got_d == c_m[h], "R6 high half keeps low", got_d, c_m[h]);
                    bus(1, 0, CB + 16'(8*h), {32'hFFFF_FFFF, cv[31:0]}, 0);
                    c_m[h] = mrg(c_m[h], {32'hFFFF_FFFF, cv[31:0]}, 0, 0);
                    bus(0, 1, CB + 16'(8*h), 0, 0);
                    chk(got_d == cv, "R6 low half keeps high", got_d, cv);
                    chk(irq[h] == (cv <= t_m), "R8 irq vs compare", 64'(irq[h]),
                        64'(cv <= t_m));
                end
            end
            bus(1, 1, CB + 16'(8*h) + 16'd4, 64'h1, 0);
            chk(got_e, "R7 err flag", 64'(got_e), 1);
            bus(0, 1, CB + 16'(8*h), 0, 0);
            chk(got_d == c_m[h], "R7 compare kept", got_d, c_m[h]);
            bus(1, 1, CB + 16'(8*h), 64'hFFFF_FFFF_FFFF_FFFF, 0); c_m[h] = '1;
            bus(0, 1, CB + 16'(8*h), 0, 0);
            chk(got_d == c_m[h], "R6 wide write", got_d, c_m[h]);
        end

        // R9 counter write re-evaluates every hart
        bus(1, 1, CB + 16'd0,  64'd100, 0); c_m[0] = 64'd100;
        bus(1, 1, CB + 16'd8,  64'd200, 0); c_m[1] = 64'd200;
        bus(1, 1, CB + 16'd16, 64'd300, 0); c_m[2] = 64'd300;
        bus(1, 1, TB, 64'd150, 0); t_m = 64'd150;
        @(negedge clk);
        chk(irq == 3'b001, "R9 partial", 64'(irq), 64'b001);
        bus(1, 0, TB, 64'd350, 0); t_m = 64'd350;
        @(negedge clk);
        chk(irq == 3'b111, "R9 all set", 64'(irq), 64'b111);
        bus(1, 1, TB, 64'd50, 0); t_m = 64'd50;
        @(negedge clk);
        chk(irq == 3'b000, "R9 all clear", 64'(irq), 64'b000);
        bus(1, 1, CB + 16'd8, 64'd20, 0); c_m[1] = 64'd20;
        chk(irq == 3'b000, "R8 registered delay", 64'(irq), 64'b000);
        @(negedge clk);
        chk(irq == 3'b010, "R8 compare below counter", 64'(irq), 64'b010);

        // R10 address sweep, both sizes
        for (int a = 0; a < 8*NH + 16; a++) begin
            for (int s = 0; s < 2; s++) begin
                bus(0, s[0], 16'(a), 0, 0);
                expect_rd(16'(a), s[0], ee, ed);
                chk(got_e == ee && got_d == ed, "R10 compare window map", got_d, ed);
            end
        end
        for (int a = int'(TB) - 8; a < int'(TB) + 8; a++) begin
            for (int s = 0; s < 2; s++) begin
                bus(0, s[0], 16'(a), 0, 0);
                expect_rd(16'(a), s[0], ee, ed);
                chk(got_e == ee && got_d == ed, "R10 counter window map", got_d, ed);
            end
        end
        bus(1, 1, CB + 16'(8*NH), 64'd0, 0);
        chk(got_e, "R10 slot beyond harts err", 64'(got_e), 1);
        bus(1, 0, CB + 16'd2, 64'd0, 0);
        chk(got_e, "R10 odd offset err", 64'(got_e), 1);
        bus(1, 1, 16'h4000, 64'd0, 0);
        chk(got_e, "R10 unmapped err", 64'(got_e), 1);
        for (int i = 0; i < NH; i++) begin
            bus(0, 1, CB + 16'(8*i), 0, 0);
            chk(got_d == c_m[i], "R10 compares untouched", got_d, c_m[i]);
        end
        bus(0, 1, TB, 0, 0);
        chk(got_d == t_m, "R10 counter untouched", got_d, t_m);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule